// File: doc/BRIEF.md
# Multi-Channel Circular Command FIFO with Debug Peek

This block holds the command queues of several channels in one shared, word-addressed RAM. Each channel owns a contiguous region of that RAM, bounded by a base pointer and an inclusive limit pointer that can be reprogrammed at run time. Per channel the block keeps a read pointer, a write pointer and a sticky error bit. A producer pushes words into a chosen channel. A consumer sees the head word of a chosen channel and pops it. Both pointers move circularly inside the channel's region.

A debug peek path lets an observer inspect the queues without disturbing them. A control word enables peeking, picks a channel and picks any RAM address. While peeking is enabled, the picked channel's read and write pointers appear on dedicated outputs. A registered data output returns the RAM word at the peek address one cycle later. Writing an all-zero control word turns peeking off.

Top module: `cmdfifo_bank`

## Requirements
- R1: After reset, channel i owns the slice with base i*(2^AW/NCH) and limit base+2^AW/NCH-1, and both of its pointers sit at that base. All channels are empty and not full, every error bit is clear, peeking is off, and peek_rd_ptr, peek_wr_ptr and peek_data are zero.
- R2: An accepted push stores push_data at the channel's write pointer. An accepted pop advances the read pointer. A pointer steps by one, except that it wraps to base after it equals the limit. pop_data shows, combinationally, the word at the read pointer of pop_ch, so words leave in the order they entered.
- R3: empty[i] is high exactly when the two pointers of channel i are equal. full[i] is high exactly when stepping the write pointer would make it equal the read pointer, so a region holds limit-base words.
- R4: A push to a full channel, or a pop from an empty channel, changes no pointer and no RAM word, and sets that channel's err bit.
- R5: An err bit stays set until reset or until a configuration write to its channel.
- R6: A configuration write with cfg_limit >= cfg_base loads the base and limit of cfg_ch, sets both of its pointers to the new base and clears its err bit. It takes precedence over a push or pop to the same channel in the same cycle; that push or pop is dropped without error. A write with cfg_limit < cfg_base is ignored.
- R7: The peek control word has bit 0 = enable, bits [CHW:1] = channel, and bits [CHW+AW:CHW+1] = address. A write with bit 0 set loads all three fields. A write with bit 0 clear turns peeking off (peek_on low).
- R8: While peeking is on, peek_rd_ptr and peek_wr_ptr show the selected channel's current pointers. While it is off, both are zero.
- R9: peek_data is registered. After the control register holds an address, the next clock edge captures the RAM word at that address; with peeking off it captures zero. Peeking changes no pointer, flag or RAM word.
- R10: A push and a pop in the same cycle both take effect, whether they target one channel or two. Acceptance is judged on the flags before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Region setup write strobe |
| cfg_ch | input | CHW | Channel being set up |
| cfg_base | input | AW | New base pointer |
| cfg_limit | input | AW | New inclusive limit pointer |
| push_valid | input | 1 | Push request |
| push_ch | input | CHW | Channel to push into |
| push_data | input | DW | Word to push |
| pop_valid | input | 1 | Pop request |
| pop_ch | input | CHW | Channel to pop from and to show on pop_data |
| pop_data | output | DW | Head word of pop_ch |
| empty | output | NCH | Per-channel empty flags |
| full | output | NCH | Per-channel full flags |
| err | output | NCH | Per-channel sticky error bits |
| peek_ctrl_we | input | 1 | Peek control write strobe |
| peek_ctrl_wdata | input | 1+CHW+AW | Peek control word {address, channel, enable} |
| peek_on | output | 1 | Peeking enabled |
| peek_rd_ptr | output | AW | Read pointer of the peeked channel |
| peek_wr_ptr | output | AW | Write pointer of the peeked channel |
| peek_data | output | DW | RAM word at the peek address, one cycle later |

## Verification
On every cycle the assertions check the following. A push that meets a full channel, or a pop that meets an empty one, raises that channel's error bit. An accepted push leaves its channel non-empty. Error bits only clear through a setup write. An all-zero peek control write turns peeking off and zeroes the pointer outputs. A cycle with no push, pop or setup leaves every flag unchanged.

The bench's scenarios show what no single-cycle property can: that words come out in order across a pointer wrap, that the capacity of each region is exactly limit minus base, and that a narrowed region wraps at its new limit. They also sweep the whole RAM through the peek port and compare it with an arithmetic model, and show that the peek data arrives only after its one-cycle latency.

// File: rtl/cmdfifo_bank.sv
module cmdfifo_bank #(
  parameter int NCH = 4,
  parameter int AW  = 6,
  parameter int DW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PCW = 1 + CHW + AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_limit,
  input  logic            push_valid,
  input  logic [CHW-1:0]  push_ch,
  input  logic [DW-1:0]   push_data,
  input  logic            pop_valid,
  input  logic [CHW-1:0]  pop_ch,
  output logic [DW-1:0]   pop_data,
  output logic [NCH-1:0]  empty,
  output logic [NCH-1:0]  full,
  output logic [NCH-1:0]  err,
  input  logic            peek_ctrl_we,
  input  logic [PCW-1:0]  peek_ctrl_wdata,
  output logic            peek_on,
  output logic [AW-1:0]   peek_rd_ptr,
  output logic [AW-1:0]   peek_wr_ptr,
  output logic [DW-1:0]   peek_data
);

  localparam int DEPTH = 2 ** AW;
  localparam int SEG   = DEPTH / NCH;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                         input logic [AW-1:0] b,
                                         input logic [AW-1:0] l);
    return (p == l) ? b : AW'(p + 1'b1);
  endfunction

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  base_v [NCH];
  logic [AW-1:0]  lim_v  [NCH];
  logic [AW-1:0]  rd_v   [NCH];
  logic [AW-1:0]  wr_v   [NCH];

  logic           peek_en_q;
  logic [CHW-1:0] peek_ch_q;
  logic [AW-1:0]  peek_addr_q;
  logic [DW-1:0]  peek_data_q;

  wire cfg_ok    = cfg_we && (cfg_limit >= cfg_base);
  wire push_fire = push_valid && !full[push_ch] && !(cfg_ok && cfg_ch == push_ch);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [AW-1:0] base_r, lim_r, rd_r, wr_r;
    logic          err_r;

    wire sel_cfg  = cfg_ok && (cfg_ch == CHW'(i));
    wire sel_push = push_valid && (push_ch == CHW'(i));
    wire sel_pop  = pop_valid && (pop_ch == CHW'(i));

    assign base_v[i] = base_r;
    assign lim_v[i]  = lim_r;
    assign rd_v[i]   = rd_r;
    assign wr_v[i]   = wr_r;
    assign err[i]    = err_r;
    assign empty[i]  = (rd_r == wr_r);
    assign full[i]   = (step(wr_r, base_r, lim_r) == rd_r);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r <= AW'(i * SEG);
        lim_r  <= AW'(i * SEG + SEG - 1);
        rd_r   <= AW'(i * SEG);
        wr_r   <= AW'(i * SEG);
        err_r  <= 1'b0;
      end else if (sel_cfg) begin
        base_r <= cfg_base;
        lim_r  <= cfg_limit;
        rd_r   <= cfg_base;
        wr_r   <= cfg_base;
        err_r  <= 1'b0;
      end else begin
        if (sel_push) begin
          if (full[i]) err_r <= 1'b1;
          else         wr_r  <= step(wr_r, base_r, lim_r);
        end
        if (sel_pop) begin
          if (empty[i]) err_r <= 1'b1;
          else          rd_r  <= step(rd_r, base_r, lim_r);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_v[push_ch]] <= push_data;
  end

  assign pop_data = mem[rd_v[pop_ch]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {peek_addr_q, peek_ch_q, peek_en_q} <= '0;
    end else if (peek_ctrl_we) begin
      if (peek_ctrl_wdata[0]) {peek_addr_q, peek_ch_q, peek_en_q} <= peek_ctrl_wdata;
      else                    {peek_addr_q, peek_ch_q, peek_en_q} <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         peek_data_q <= '0;
    else if (peek_en_q) peek_data_q <= mem[peek_addr_q];
    else                peek_data_q <= '0;
  end

  assign peek_on     = peek_en_q;
  assign peek_rd_ptr = peek_en_q ? rd_v[peek_ch_q] : '0;
  assign peek_wr_ptr = peek_en_q ? wr_v[peek_ch_q] : '0;
  assign peek_data   = peek_data_q;

endmodule

// File: rtl/cmdfifo_bank_chk.sv
module cmdfifo_bank_chk #(
  parameter int NCH = 4,
  parameter int AW  = 6,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PCW = 1 + CHW + AW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [CHW-1:0] cfg_ch,
  input logic [AW-1:0]  cfg_base,
  input logic [AW-1:0]  cfg_limit,
  input logic           push_valid,
  input logic [CHW-1:0] push_ch,
  input logic           pop_valid,
  input logic [CHW-1:0] pop_ch,
  input logic [NCH-1:0] empty,
  input logic [NCH-1:0] full,
  input logic [NCH-1:0] err,
  input logic           peek_ctrl_we,
  input logic [PCW-1:0] peek_ctrl_wdata,
  input logic           peek_on,
  input logic [AW-1:0]  peek_rd_ptr,
  input logic [AW-1:0]  peek_wr_ptr
);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    wire hit = cfg_we && (cfg_limit >= cfg_base) && (cfg_ch == CHW'(i));
    wire ph  = push_valid && (push_ch == CHW'(i));
    wire oh  = pop_valid && (pop_ch == CHW'(i));

    // R4
    push_full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph && full[i] && !hit |=> err[i]);

    // R4
    pop_empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oh && empty[i] && !hit |=> err[i]);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err[i] && !hit |=> err[i]);

    // R3
    push_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph && !full[i] && !hit && !oh |=> !empty[i]);
  end

  // R7
  peek_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peek_ctrl_we && (peek_ctrl_wdata == '0) |=> !peek_on && peek_rd_ptr == '0 && peek_wr_ptr == '0);

  // R9
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid && !pop_valid && !cfg_we |=> $stable(empty) && $stable(full) && $stable(err));

endmodule

bind cmdfifo_bank cmdfifo_bank_chk #(.NCH(NCH), .AW(AW)) chk_i (.*);

// File: tb/cmdfifo_bank_test.sv
`timescale 1ns/1ps
module cmdfifo_bank_test;
  localparam int NCH = 4, AW = 5, DW = 16, CHW = 2, SEG = 8, DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [CHW-1:0] cfg_ch = 0; logic [AW-1:0] cfg_base = 0, cfg_limit = 0;
  logic push_valid = 0; logic [CHW-1:0] push_ch = 0; logic [DW-1:0] push_data = 0;
  logic pop_valid = 0; logic [CHW-1:0] pop_ch = 0; logic [DW-1:0] pop_data;
  logic [NCH-1:0] empty, full, err;
  logic peek_ctrl_we = 0; logic [1+CHW+AW-1:0] peek_ctrl_wdata = 0;
  logic peek_on; logic [AW-1:0] peek_rd_ptr, peek_wr_ptr; logic [DW-1:0] peek_data;

  cmdfifo_bank #(.NCH(NCH), .AW(AW), .DW(DW)) uut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0; bit done = 0;
  int mb[NCH], ml[NCH], mr[NCH], mw[NCH]; bit me[NCH];
  logic [DW-1:0] mm[DEPTH]; bit mv[DEPTH];

  function automatic int m_step(int c, int p); return (p == ml[c]) ? mb[c] : p + 1; endfunction
  function automatic bit m_empty(int c); return mr[c] == mw[c]; endfunction
  function automatic bit m_full(int c); return m_step(c, mw[c]) == mr[c]; endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic cyc; @(posedge clk); #2; endtask

  task automatic chk_flags(input string tag);
    logic [NCH-1:0] ee, ef, er;
    for (int c = 0; c < NCH; c++) begin ee[c] = m_empty(c); ef[c] = m_full(c); er[c] = me[c]; end
    chk(empty == ee, {tag, " empty"}, empty, ee);
    chk(full == ef, {tag, " full"}, full, ef);
    chk(err == er, {tag, " err"}, err, er);
  endtask

  task automatic do_op(input bit pv, input int pc, input int pd, input bit ov, input int oc);
    bit pok, ook;
    push_valid = pv; push_ch = CHW'(pc); push_data = DW'(pd);
    pop_valid = ov; pop_ch = CHW'(oc);
    pok = pv && !m_full(pc); ook = ov && !m_empty(oc);
    #1;
    if (ook) chk(pop_data == mm[mr[oc]], "R2 pop head word", pop_data, mm[mr[oc]]);
    if (pv && !pok) me[pc] = 1;
    if (ov && !ook) me[oc] = 1;
    if (pok) begin mm[mw[pc]] = DW'(pd); mv[mw[pc]] = 1; mw[pc] = m_step(pc, mw[pc]); end
    if (ook) mr[oc] = m_step(oc, mr[oc]);
    cyc; push_valid = 0; pop_valid = 0;
  endtask

  task automatic do_cfg(input int c, input int b, input int l, input bit pv);
    cfg_we = 1; cfg_ch = CHW'(c); cfg_base = AW'(b); cfg_limit = AW'(l);
    push_valid = pv; push_ch = CHW'(c); push_data = 16'hbeef;
    if (l >= b) begin mb[c] = b; ml[c] = l; mr[c] = b; mw[c] = b; me[c] = 0; end
    cyc; cfg_we = 0; push_valid = 0;
  endtask

  task automatic peek_cfg(input int c, input int a);
    peek_ctrl_we = 1; peek_ctrl_wdata = {AW'(a), CHW'(c), 1'b1};
    cyc; peek_ctrl_we = 0;
  endtask

  task automatic chk_ptrs(input int c, input string tag);
    peek_cfg(c, 0);
    chk(peek_rd_ptr == AW'(mr[c]), {tag, " rd ptr"}, peek_rd_ptr, mr[c]);
    chk(peek_wr_ptr == AW'(mw[c]), {tag, " wr ptr"}, peek_wr_ptr, mw[c]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mb[c] = c * SEG; ml[c] = c * SEG + SEG - 1; mr[c] = mb[c]; mw[c] = mb[c]; me[c] = 0;
    end
    for (int a = 0; a < DEPTH; a++) begin mm[a] = 0; mv[a] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    chk_flags("R1 reset");
    chk(peek_on == 0, "R1 peek off", peek_on, 0);
    chk(peek_rd_ptr == 0 && peek_wr_ptr == 0, "R1 peek ptrs zero", peek_rd_ptr, 0);
    chk(peek_data == 0, "R1 peek data zero", peek_data, 0);
    cyc;
    for (int c = 0; c < NCH; c++) chk_ptrs(c, "R1 region base R8");

    // fill and drain every channel
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < SEG - 1; k++) begin
        do_op(1, c, c * 256 + k, 0, 0);
        chk_flags("R3 fill");
      end
      do_op(1, c, 16'hdead, 0, 0);
      chk_flags("R4 push on full");
      chk_ptrs(c, "R4 pointers held");
      do_op(0, 0, 0, 0, 0); do_op(0, 0, 0, 0, 0);
      chk_flags("R5 err sticky");
      for (int k = 0; k < SEG - 1; k++) do_op(0, 0, 0, 1, c);
      chk_flags("R3 empty after drain");
      do_op(0, 0, 0, 1, c);
      chk_flags("R4 pop on empty");
      do_op(1, (c + 1) % NCH, 16'h0a0a, 0, 0);
      do_op(0, 0, 0, 1, (c + 1) % NCH);
      chk_flags("R5 err kept over other traffic");
      do_cfg(c, c * SEG, c * SEG + SEG - 1, 0);
      chk_flags("R6 cfg clears err");
    end

    // R2 explicit wrap: eight push/pop pairs return pointers to base
    for (int k = 0; k < SEG; k++) begin do_op(1, 0, 16'h5000 + k, 0, 0); do_op(0, 0, 0, 1, 0); end
    chk_ptrs(0, "R2 wrap back to base");

    // R10 mixed stream on channel 1
    for (int n = 0; n < 40; n++) begin
      do_op((n % 3) != 2, 1, 16'h100 + n, (n % 2) == 1, 1);
      chk_flags("R10 mixed flags");
    end
    chk_ptrs(1, "R10 mixed pointers");
    do_op(1, 2, 16'h2222, 0, 0);
    do_op(1, 2, 16'h2223, 1, 2);
    chk_flags("R10 same channel push and pop");
    chk_ptrs(2, "R10 both pointers advanced");
    do_op(1, 3, 16'h3333, 1, 2);
    chk_flags("R10 different channels");

    // R6 region programming
    do_cfg(3, 30, 25, 0);
    chk_ptrs(3, "R6 bad cfg ignored");
    chk_flags("R6 bad cfg ignored");
    do_cfg(2, 16, 18, 1);
    chk_ptrs(2, "R6 cfg wins over push");
    chk_flags("R6 cfg wins over push");
    do_op(1, 2, 16'h7001, 0, 0);
    do_op(1, 2, 16'h7002, 0, 0);
    chk_flags("R3 narrow region full");
    do_op(0, 0, 0, 1, 2);
    do_op(1, 2, 16'h7003, 0, 0);
    chk_ptrs(2, "R2 wrap at new limit");
    do_op(0, 0, 0, 1, 2); do_op(0, 0, 0, 1, 2);
    chk_flags("R2 narrow region drained");

    // R9 peek sweep of the whole RAM
    peek_cfg(0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      peek_cfg(a % NCH, a);
      cyc;
      if (mv[a]) chk(peek_data == mm[a], "R9 peek word", peek_data, mm[a]);
    end
    chk_flags("R9 peek has no side effect");
    for (int c = 0; c < NCH; c++) chk_ptrs(c, "R9 peek keeps pointers");

    // R9 one-cycle latency
    peek_cfg(0, 1);
    cyc;
    peek_cfg(0, 2);
    chk(peek_data == mm[1], "R9 old word before latency", peek_data, mm[1]);
    cyc;
    chk(peek_data == mm[2], "R9 new word after latency", peek_data, mm[2]);

    // R7 disable with enable clear but other fields set
    peek_ctrl_we = 1; peek_ctrl_wdata = {AW'(5), CHW'(1), 1'b0};
    cyc; peek_ctrl_we = 0;
    chk(peek_on == 0, "R7 enable clear disables", peek_on, 0);
    chk(peek_rd_ptr == 0 && peek_wr_ptr == 0, "R8 ptrs zero when off", peek_wr_ptr, 0);
    cyc;
    chk(peek_data == 0, "R9 data zero when off", peek_data, 0);
    peek_cfg(3, 0);
    chk(peek_on == 1, "R7 enable set", peek_on, 1);
    peek_ctrl_we = 1; peek_ctrl_wdata = '0;
    cyc; peek_ctrl_we = 0;
    chk(peek_on == 0, "R7 zero write disables", peek_on, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule